// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block builds the three clocks of an audio serial link from one root audio clock. A prescaler divides the root clock to form a master clock for the codec. The block then divides that master clock down to a bit clock and a left/right frame clock. Each of these two runs at a chosen multiple of the sample rate. The whole design runs in the root clock domain. The master clock, bit clock and frame clock are registered outputs that toggle on root-clock edges.

As clock master, the block drives the bit and frame clocks. As slave, it leaves those pins undriven. It then samples the bit and frame clocks arriving from outside and only produces edge strobes for the serializer. The codec clock pin can also be turned around. In that case the block stops driving the master clock and takes its timing from the edges of the incoming codec clock. Configuration comes from a simple write-only register port, and every write restarts the dividers from a known phase.

Top module: `audio_clkgen`

## Requirements
- R1: After reset, bclk_o, lrclk_o, mclk_o, bit_fall_stb, frame_stb and ratio_err are 0. The block is master with the codec clock driven (mclk_oe, bclk_oe and lrclk_oe are 1). The master ratio is 256, the bit ratio is 32 and the prescaler is disabled.
- R2: Register 1 field [9:0] requests the master-clock ratio: 256, 384, 512 or 768 master clocks per frame. The lrclk period equals that many master-clock half-ticks times two. In root cycles, the spacing of frame_stb is ratio × tick period, where a tick is one master-clock half period.
- R3: A register-1 request of any value other than 256, 384, 512 or 768 selects 256.
- R4: Register 2 field [5:0] selects 16, 24, 32 or 48 bit clocks per frame. The bit clock period is 2 × floor(master ratio / bit ratio) ticks. lrclk toggles on every (bit ratio / 2)-th falling edge of the bit clock.
- R5: A register-2 write with any other value is ignored, and the previous bit ratio stays in force.
- R6: Register 3 holds the prescaler: bit 8 enables it and [7:0] is the divide value d. The tick period is d+1 root cycles when the prescaler is enabled and 1 root cycle when it is disabled. With the codec clock driven, mclk_o toggles once per tick.
- R7: ratio_err is 1 exactly when the master ratio is not a multiple of the bit ratio. In that case the divider still uses the truncated quotient.
- R8: Register 0 bit 1 = 1 drives the codec clock (mclk_oe=1). A value of 0 releases it: mclk_oe=0, mclk_o is held at 0, and each edge of the synchronized mclk_i counts as one tick.
- R9: Register 0 bit 0 = 1 selects master mode. A value of 0 selects slave mode: bclk_oe=lrclk_oe=0, and bclk_o and lrclk_o are held at 0. In slave mode, bit_fall_stb pulses once per falling edge of bclk_i and frame_stb pulses once per transition of lrclk_i, both after synchronization.
- R10: In master mode, bit_fall_stb is high for one cycle, in the cycle in which bclk_o has just fallen. frame_stb is high in the cycle in which lrclk_o has just toggled, and it always coincides with bit_fall_stb.
- R11: Any register write clears bclk_o, lrclk_o, mclk_o and all divider counters on the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root audio clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 control, 1 master ratio, 2 bit ratio, 3 prescaler) |
| cfg_wdata | input | 16 | Register write data |
| mclk_i | input | 1 | Codec clock input, used when the codec clock is released |
| mclk_o | output | 1 | Generated master clock |
| mclk_oe | output | 1 | Drive enable for the codec clock pin |
| bclk_i | input | 1 | Bit clock input in slave mode |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Drive enable for the bit clock pin |
| lrclk_i | input | 1 | Frame clock input in slave mode |
| lrclk_o | output | 1 | Generated frame clock |
| lrclk_oe | output | 1 | Drive enable for the frame clock pin |
| bit_fall_stb | output | 1 | One-cycle strobe on a bit-clock falling edge |
| frame_stb | output | 1 | One-cycle strobe on a frame-clock transition |
| ratio_err | output | 1 | Master ratio not a multiple of bit ratio |

## Verification
The hardest state to reach is a pairing of ratios that does not divide evenly, running behind a nonzero prescaler. In that state the frame spacing follows from the truncated quotient, not from the master ratio. Constrained random writes draw legal and illegal ratio requests together with random divide values and enable bits. The bench predicts every interval from its own model of what was kept and what was rejected. The bench spaces the bit, frame and master clock events from its predicted configuration and measures them once the first period after the restart has passed. Directed cases then release the codec clock while driving a slow external clock, and switch to slave mode with bench-driven bit and frame clocks.

// File: rtl/aclkgen_pkg.sv
package aclkgen_pkg;
  localparam int HC_W   = 6;   // ticks per half bit clock, up to 48
  localparam int FC_W   = 5;   // falls per half frame, up to 24
  localparam int MREQ_W = 10;  // master ratio request field
  localparam int BREQ_W = 6;   // bit ratio request field

  // master ratio request -> code, fallback to 256
  function automatic logic [1:0] mcode_from_req(input logic [MREQ_W-1:0] req);
    case (req)
      10'd384: return 2'd1;
      10'd512: return 2'd2;
      10'd768: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic breq_legal(input logic [BREQ_W-1:0] req);
    return (req == 6'd16) || (req == 6'd24) || (req == 6'd32) || (req == 6'd48);
  endfunction

  function automatic logic [1:0] bcode_from_req(input logic [BREQ_W-1:0] req);
    case (req)
      6'd24:   return 2'd1;
      6'd32:   return 2'd2;
      6'd48:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // truncated master/bit ratio: ticks per bit clock half period
  function automatic logic [HC_W-1:0] half_ticks_of(input logic [1:0] mc,
                                                    input logic [1:0] bc);
    case ({mc, bc})
      4'b00_00: return 6'd16;
      4'b00_01: return 6'd10;
      4'b00_10: return 6'd8;
      4'b00_11: return 6'd5;
      4'b01_00: return 6'd24;
      4'b01_01: return 6'd16;
      4'b01_10: return 6'd12;
      4'b01_11: return 6'd8;
      4'b10_00: return 6'd32;
      4'b10_01: return 6'd21;
      4'b10_10: return 6'd16;
      4'b10_11: return 6'd10;
      4'b11_00: return 6'd48;
      4'b11_01: return 6'd32;
      4'b11_10: return 6'd24;
      default:  return 6'd16;
    endcase
  endfunction

  function automatic logic ratio_uneven(input logic [1:0] mc, input logic [1:0] bc);
    return (bc[0] == 1'b1) && (mc[0] == 1'b0);
  endfunction

  // bit clock falling edges per half frame
  function automatic logic [FC_W-1:0] half_falls_of(input logic [1:0] bc);
    case (bc)
      2'd0:    return 5'd8;
      2'd1:    return 5'd12;
      2'd2:    return 5'd16;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/aclkgen_cfg.sv
module aclkgen_cfg
  import aclkgen_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              master_q,
  output logic              cd_out_q,
  output logic [1:0]        mcode_q,
  output logic [1:0]        bcode_q,
  output logic              pre_en_q,
  output logic [PRE_W-1:0]  pre_div_q,
  output logic              restart
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MRAT = 2'd1;
  localparam logic [1:0] A_BRAT = 2'd2;
  localparam logic [1:0] A_PRE  = 2'd3;

  logic [MREQ_W-1:0] mreq;
  logic [BREQ_W-1:0] breq;
  logic              unused_hi;

  assign mreq      = wdata[MREQ_W-1:0];
  assign breq      = wdata[BREQ_W-1:0];
  assign unused_hi = ^wdata[DATA_W-1:MREQ_W];
  assign restart   = we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q  <= 1'b1;
      cd_out_q  <= 1'b1;
      mcode_q   <= 2'd0;
      bcode_q   <= 2'd2;
      pre_en_q  <= 1'b0;
      pre_div_q <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          master_q <= wdata[0];
          cd_out_q <= wdata[1];
        end
        A_MRAT: mcode_q <= mcode_from_req(mreq);
        A_BRAT: if (breq_legal(breq)) bcode_q <= bcode_from_req(breq);
        A_PRE: begin
          pre_en_q  <= wdata[PRE_W];
          pre_div_q <= wdata[PRE_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/aclkgen_tick.sv
module aclkgen_tick #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cd_out,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre_div,
  input  logic             mclk_i,
  output logic             tick,
  output logic             mclk_o
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic             int_tick;
  logic             ext_tick;
  logic [2:0]       ext_sync;

  assign pre_lim  = pre_en ? pre_div : '0;
  assign int_tick = (pre_cnt == pre_lim);
  assign ext_tick = ext_sync[1] ^ ext_sync[2];
  assign tick     = cd_out ? int_tick : ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      mclk_o  <= 1'b0;
    end else if (restart) begin
      pre_cnt <= '0;
      mclk_o  <= 1'b0;
    end else begin
      pre_cnt <= int_tick ? '0 : pre_cnt + 1'b1;
      if (cd_out && int_tick) mclk_o <= ~mclk_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], mclk_i};
  end
endmodule

// File: rtl/aclkgen_master.sv
module aclkgen_master
  import aclkgen_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [HC_W-1:0] half_ticks,
  input  logic [FC_W-1:0] half_falls,
  output logic            bclk,
  output logic            lrclk,
  output logic            fall_stb,
  output logic            frame_stb
);
  logic [HC_W-1:0] hc;
  logic [FC_W-1:0] fc;
  logic            half_done;
  logic            frame_done;

  assign half_done  = (hc == half_ticks - 1'b1);
  assign frame_done = (fc == half_falls - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; fc <= '0; bclk <= 1'b0; lrclk <= 1'b0;
      fall_stb <= 1'b0; frame_stb <= 1'b0;
    end else if (clr) begin
      hc <= '0; fc <= '0; bclk <= 1'b0; lrclk <= 1'b0;
      fall_stb <= 1'b0; frame_stb <= 1'b0;
    end else begin
      fall_stb  <= 1'b0;
      frame_stb <= 1'b0;
      if (tick) begin
        if (half_done) begin
          hc   <= '0;
          bclk <= ~bclk;
          if (bclk) begin
            fall_stb <= 1'b1;
            if (frame_done) begin
              fc        <= '0;
              lrclk     <= ~lrclk;
              frame_stb <= 1'b1;
            end else begin
              fc <= fc + 1'b1;
            end
          end
        end else begin
          hc <= hc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aclkgen_slave.sv
module aclkgen_slave (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic fall_stb,
  output logic frame_stb
);
  logic [2:0] b_sync;
  logic [2:0] l_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sync <= '0;
      l_sync <= '0;
    end else begin
      b_sync <= {b_sync[1:0], bclk_i};
      l_sync <= {l_sync[1:0], lrclk_i};
    end
  end

  assign fall_stb  = b_sync[2] & ~b_sync[1];
  assign frame_stb = l_sync[2] ^ l_sync[1];
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import aclkgen_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              mclk_i,
  output logic              mclk_o,
  output logic              mclk_oe,
  input  logic              bclk_i,
  output logic              bclk_o,
  output logic              bclk_oe,
  input  logic              lrclk_i,
  output logic              lrclk_o,
  output logic              lrclk_oe,
  output logic              bit_fall_stb,
  output logic              frame_stb,
  output logic              ratio_err
);
  logic             master_q, cd_out_q, pre_en_q, restart, tick;
  logic [1:0]       mcode_q, bcode_q;
  logic [PRE_W-1:0] pre_div_q;
  logic [HC_W-1:0]  half_ticks;
  logic [FC_W-1:0]  half_falls;
  logic             m_bclk, m_lrclk, m_fall, m_frame;
  logic             s_fall, s_frame;
  logic             div_clr;

  aclkgen_cfg #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .master_q(master_q), .cd_out_q(cd_out_q), .mcode_q(mcode_q),
    .bcode_q(bcode_q), .pre_en_q(pre_en_q), .pre_div_q(pre_div_q),
    .restart(restart)
  );

  aclkgen_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cd_out(cd_out_q),
    .pre_en(pre_en_q), .pre_div(pre_div_q), .mclk_i(mclk_i),
    .tick(tick), .mclk_o(mclk_o)
  );

  assign half_ticks = half_ticks_of(mcode_q, bcode_q);
  assign half_falls = half_falls_of(bcode_q);
  assign div_clr    = restart | ~master_q;

  aclkgen_master u_master (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .tick(tick),
    .half_ticks(half_ticks), .half_falls(half_falls),
    .bclk(m_bclk), .lrclk(m_lrclk), .fall_stb(m_fall), .frame_stb(m_frame)
  );

  aclkgen_slave u_slave (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .fall_stb(s_fall), .frame_stb(s_frame)
  );

  assign mclk_oe      = cd_out_q;
  assign bclk_oe      = master_q;
  assign lrclk_oe     = master_q;
  assign bclk_o       = m_bclk;
  assign lrclk_o      = m_lrclk;
  assign bit_fall_stb = master_q ? m_fall  : s_fall;
  assign frame_stb    = master_q ? m_frame : s_frame;
  assign ratio_err    = ratio_uneven(mcode_q, bcode_q);
endmodule

// File: rtl/aclkgen_chk.sv
module aclkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic master,
  input logic tick,
  input logic restart,
  input logic mclk_o,
  input logic bclk_o,
  input logic lrclk_o,
  input logic bclk_oe,
  input logic bit_fall_stb,
  input logic frame_stb
);
  // R10: fall strobe marks a real falling edge of the generated bit clock
  p_fall_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && bit_fall_stb |-> !bclk_o && $past(bclk_o));

  // R10: frame strobe marks an lrclk toggle
  p_frame_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && frame_stb |-> lrclk_o != $past(lrclk_o));

  // R10: frame transition only on a bit clock fall
  p_frame_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    master && frame_stb |-> bit_fall_stb);

  // R10: strobes last one cycle in master mode
  p_fall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    master && bit_fall_stb |=> !bit_fall_stb);

  // R9: slave mode leaves generated clocks quiet
  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !bclk_o && !lrclk_o && !bclk_oe);

  // R6: master clock moves only on a tick
  p_mclk_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_o != $past(mclk_o)) && !$past(restart) |-> $past(tick));

  // R4: bit clock moves only on a tick
  p_bclk_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_o != $past(bclk_o)) && !$past(restart) && $past(master) |-> $past(tick));

  // R11: a write clears the clocks
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !bclk_o && !lrclk_o && !mclk_o);
endmodule

bind audio_clkgen aclkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .master(master_q), .tick(tick),
  .restart(restart), .mclk_o(mclk_o), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
  .bclk_oe(bclk_oe), .bit_fall_stb(bit_fall_stb), .frame_stb(frame_stb)
);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        mclk_i = 1'b0, bclk_i = 1'b0, lrclk_i = 1'b0;
  logic        mclk_o, mclk_oe, bclk_o, bclk_oe, lrclk_o, lrclk_oe;
  logic        bit_fall_stb, frame_stb, ratio_err;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  bit ext_run = 1'b0;
  int ph = 0;
  bit counting = 1'b0;
  int n_fall = 0, n_frame = 0;

  // bench model of the configuration
  int m_rat = 256, b_rat = 32, p_div = 0;
  bit p_en = 1'b0;

  always #2.5 clk = ~clk;

  audio_clkgen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mclk_i(mclk_i), .mclk_o(mclk_o), .mclk_oe(mclk_oe),
    .bclk_i(bclk_i), .bclk_o(bclk_o), .bclk_oe(bclk_oe), .lrclk_i(lrclk_i),
    .lrclk_o(lrclk_o), .lrclk_oe(lrclk_oe), .bit_fall_stb(bit_fall_stb),
    .frame_stb(frame_stb), .ratio_err(ratio_err)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (ext_run) begin
      if (ph == 2) begin ph <= 0; mclk_i <= ~mclk_i; end
      else ph <= ph + 1;
    end
    if (counting) begin
      n_fall  <= n_fall + int'(bit_fall_stb);
      n_frame <= n_frame + int'(frame_stb);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int m_model(input int req);
    if (req == 384 || req == 512 || req == 768) return req;
    return 256;
  endfunction

  function automatic bit b_legal(input int req);
    return req == 16 || req == 24 || req == 32 || req == 48;
  endfunction

  function automatic int tick_len();
    return p_en ? p_div + 1 : 1;
  endfunction

  function automatic int fall_len(input int tl);
    return 2 * (m_rat / b_rat) * tl;
  endfunction

  function automatic int frame_len(input int tl);
    return b_rat * (m_rat / b_rat) * tl;
  endfunction

  // sel 0: bit fall strobe, 1: frame strobe, 2: mclk_o rising edge
  task automatic wait_ev(input int sel, output int t, output logic lv);
    logic prev;
    prev = mclk_o;
    t = -1; lv = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if ((sel == 0 && bit_fall_stb) || (sel == 1 && frame_stb) ||
          (sel == 2 && mclk_o && !prev)) begin
        t = cyc; lv = lrclk_o;
        return;
      end
      prev = mclk_o;
    end
  endtask

  task automatic interval(input int sel, output int iv, output bit lr_flip);
    int t0, t1, t2;
    logic l0, l1, l2;
    wait_ev(sel, t0, l0);
    wait_ev(sel, t1, l1);
    wait_ev(sel, t2, l2);
    iv = (t1 < 0 || t2 < 0) ? -1 : t2 - t1;
    lr_flip = (l2 != l1);
  endtask

  task automatic check_timing(input string tag, input int tl);
    int iv;
    bit fl;
    interval(0, iv, fl);
    chk({tag, " R4 bit clock period"}, iv, fall_len(tl));
    interval(1, iv, fl);
    chk({tag, " R2 frame spacing"}, iv, frame_len(tl));
    chk({tag, " R10 lrclk toggles at frame strobe"}, int'(fl), 1);
    chk({tag, " R7 ratio_err"}, int'(ratio_err), int'((m_rat % b_rat) != 0));
  endtask

  initial begin
    int iv, mreq, breq, r;
    bit fl;
    void'($urandom(32'h5EED_0C1C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bclk_o", int'(bclk_o), 0);
    chk("R1 lrclk_o", int'(lrclk_o), 0);
    chk("R1 strobes", int'(bit_fall_stb | frame_stb), 0);
    chk("R1 ratio_err", int'(ratio_err), 0);
    chk("R1 output enables", int'({mclk_oe, bclk_oe, lrclk_oe}), 7);
    check_timing("R1 defaults", 1);
    interval(2, iv, fl);
    chk("R6 mclk period, prescaler off", iv, 2);

    // R3 fallback
    wr(2'd1, 16'd300); m_rat = m_model(300);
    check_timing("R3 fallback to 256", 1);

    // R5 illegal bit ratio ignored
    wr(2'd2, 16'd16); b_rat = 16;
    wr(2'd2, 16'd40);
    check_timing("R5 illegal bit ratio kept", 1);

    // R7 uneven pair
    wr(2'd2, 16'd24); b_rat = 24;
    check_timing("R7 uneven 256/24", 1);

    // R11 restart clears clocks
    wr(2'd2, 16'd16); b_rat = 16;
    for (int k = 0; k < 4000 && !(bclk_o && lrclk_o); k++) @(negedge clk);
    chk("R11 precondition high", int'(bclk_o && lrclk_o), 1);
    wr(2'd3, 16'h0000);
    chk("R11 clocks cleared", int'({bclk_o, lrclk_o, mclk_o}), 0);

    // constrained random mix (R2 R4 R5 R6 R7)
    for (int it = 0; it < 10; it++) begin
      r = $urandom % 5;
      mreq = (r == 0) ? 256 : (r == 1) ? 384 : (r == 2) ? 512 : (r == 3) ? 768
             : 257 + ($urandom % 100);
      r = $urandom % 5;
      breq = (r == 0) ? 16 : (r == 1) ? 24 : (r == 2) ? 32 : (r == 3) ? 48
             : 50 + ($urandom % 10);
      p_div = $urandom % 3;
      p_en  = 1'($urandom % 2);
      wr(2'd1, 16'(mreq)); m_rat = m_model(mreq);
      wr(2'd2, 16'(breq)); if (b_legal(breq)) b_rat = breq;
      wr(2'd3, {7'd0, p_en, 8'(p_div)});
      interval(2, iv, fl);
      chk("R6 mclk period", iv, 2 * tick_len());
      check_timing("R2 random", tick_len());
    end

    // R8 codec clock released, timing from mclk_i (half period 3 cycles)
    wr(2'd1, 16'd256); m_rat = 256;
    wr(2'd2, 16'd32);  b_rat = 32;
    ext_run = 1'b1;
    wr(2'd0, 16'h0001);
    chk("R8 mclk_oe released", int'(mclk_oe), 0);
    interval(0, iv, fl);
    chk("R8 bit clock from mclk_i", iv, fall_len(3));
    chk("R8 mclk_o held low", int'(mclk_o), 0);
    ext_run = 1'b0;

    // R9 slave mode
    wr(2'd0, 16'h0002);
    chk("R9 enables off", int'({bclk_oe, lrclk_oe}), 0);
    n_fall = 0; n_frame = 0;
    @(negedge clk);
    counting = 1'b1;
    for (int k = 0; k < 16; k++) begin
      bclk_i = 1'b1;
      repeat (4) @(negedge clk);
      bclk_i = 1'b0;
      if (k % 4 == 3) lrclk_i = ~lrclk_i;
      repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    counting = 1'b0;
    @(negedge clk);
    chk("R9 slave fall strobes", n_fall, 16);
    chk("R9 slave frame strobes", n_frame, 4);
    chk("R9 outputs held low", int'({bclk_o, lrclk_o}), 0);

    done = 1'b1;
    summary();
  end
endmodule